// File: doc/BRIEF.md
# Serial-Priority Interrupt Slot

This block is the interrupt logic of one card in a serial priority chain. Each card has a chain-enable input from the card above it and a chain-enable output to the card below it. The card nearest the processor has its chain input tied enabled. Priority depends only on position along this chain. When the local device asks for service, the slot latches the request. It then pulls the shared active-low request line, which any card may pull, and withdraws the chain enable from every card below it.

When the processor acknowledges the interrupt, it drives the active-low acknowledge line low. The requesting slot that still sees an enabled chain input then puts its switch-selected vector on the data bus. Every slot below a requester sees a disabled chain and keeps its driver off. The latched request is dropped when the acknowledge ends, provided the slot supplied its vector in that acknowledge. Slots that requested but were not served keep their requests and compete again in the next acknowledge.

The open-drain request line and the tri-state vector driver are given as an enable plus a data value (`intrq_pull`, `data_oe`, `data_out`), and the board-level wiring resolves them. The acknowledge input is brought into the clock domain through a synchronizer whose depth is a parameter. A mode parameter can make a card a non-participant. Such a card passes its chain input straight to its chain output and never requests or drives.

Top module: `intchain_slot`

## Requirements
- R1: After reset no request is latched: `intrq_pull` and `data_oe` are 0, and `chain_out` equals `chain_in`.
- R2: In arbitrating mode, `dev_req` high at a rising clock edge latches the request, and `intrq_pull` is 1 from that edge on.
- R3: `chain_out` is 1 exactly when `chain_in` is 1 and no request is latched. The path is combinational with no clock delay.
- R4: `data_oe` is 1 only when all three hold: the synchronized acknowledge is active, a request is latched and `chain_in` is 1. While `data_oe` is 1, `data_out` equals `vec_sel`; otherwise `data_out` is 0. The acknowledge (`intak_n` low) takes effect SYNC_STAGES (default 2) clock edges after it is applied.
- R5: In a chain, only the requester nearest the processor (the lowest position) drives during an acknowledge. The bus then carries that slot's vector, and exactly one `data_oe` is high.
- R6: A latched request is cleared when the synchronized acknowledge ends, but only if the slot drove its vector during that acknowledge. Requesters that did not drive keep their request and keep pulling the request line.
- R7: In pass-through mode, `chain_out` always equals `chain_in`. `intrq_pull` and `data_oe` stay 0 whatever `dev_req` and `intak_n` do.
- R8: An acknowledge while no slot holds a request leaves every `data_oe` at 0, and no request appears as a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_req | input | 1 | Local device service request, active high |
| vec_sel | input | VEC_W | Switch-selected interrupt vector |
| chain_in | input | 1 | Chain enable from the higher-priority neighbour (tie 1 on the first slot) |
| chain_out | output | 1 | Chain enable to the lower-priority neighbour |
| intak_n | input | 1 | Processor interrupt acknowledge, active low, asynchronous |
| intrq_pull | output | 1 | Pull-low enable for the shared active-low request line |
| data_out | output | VEC_W | Vector value for the data bus, 0 when not driving |
| data_oe | output | 1 | Output enable of the tri-state vector driver |

## Verification
A request latch that is stuck or wrongly set shows at once on `intrq_pull`. In the same cycle, the chain enable is lost or restored for every card below, so one sample of all chain outputs finds it. A wrong served flag or clearing rule shows only after the acknowledge ends. Either a request that was served is still pulling the line a few cycles later, or a request that was not served has vanished; both are seen before the next acknowledge. Gating mistakes in the vector driver show during the acknowledge window as two drivers, no driver, or the wrong vector on the resolved bus.

// File: rtl/intchain_pkg.sv
// Package: shared types for the serial-priority interrupt slot.
// Assumes: nothing beyond IEEE 1800-2017.
package intchain_pkg;

    // Whether a card takes part in arbitration or only forwards the chain.
    typedef enum logic {
        MODE_PASS = 1'b0,
        MODE_ARB  = 1'b1
    } slot_mode_e;

endpackage

// File: rtl/intchain_ack_sync.sv
// Module: brings the asynchronous active-low acknowledge into the clock
// domain and flags the cycle in which the synchronized acknowledge ends.
// Assumes: STAGES >= 0; with 0 the input is used unsynchronized.
module intchain_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic intak_n,
    output logic ack,
    output logic ack_end
);
    logic ack_prev;

    generate
        if (STAGES == 0) begin : g_direct
            assign ack = ~intak_n;
        end else begin : g_sync
            logic [STAGES-1:0] shreg;
            // Shift the inverted acknowledge through the synchronizer.
            always_ff @(posedge clk) begin
                if (!rst_n) shreg <= '0;
                else        shreg <= {shreg[STAGES-2 >= 0 ? STAGES-2 : 0:0], ~intak_n} & {STAGES{1'b1}};
            end
            assign ack = shreg[STAGES-1];
        end
    endgenerate

    // Remember the previous acknowledge level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_prev <= 1'b0;
        else        ack_prev <= ack;
    end

    assign ack_end = ack_prev & ~ack;
endmodule

// File: rtl/intchain_req_latch.sv
// Module: holds the local service request until it has been served.
// Assumes: a clear takes priority over a set in the same cycle.
module intchain_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic req_q
);
    // Set on a device request, clear once served.
    always_ff @(posedge clk) begin
        if (!rst_n)       req_q <= 1'b0;
        else if (clr_req) req_q <= 1'b0;
        else if (set_req) req_q <= 1'b1;
    end
endmodule

// File: rtl/intchain_vec_drive.sv
// Module: gates the vector driver and records whether this slot supplied
// its vector during the current acknowledge.
// Assumes: ack and ack_end come from the same synchronizer.
module intchain_vec_drive #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    input  logic             ack_end,
    input  logic             req_q,
    input  logic             chain_in,
    input  logic [VEC_W-1:0] vec_sel,
    output logic             oe,
    output logic [VEC_W-1:0] data,
    output logic             served_q
);
    assign oe   = ack & req_q & chain_in;
    assign data = oe ? vec_sel : '0;

    // Mark the slot served while driving; forget it when the acknowledge ends.
    always_ff @(posedge clk) begin
        if (!rst_n)       served_q <= 1'b0;
        else if (ack_end) served_q <= 1'b0;
        else if (oe)      served_q <= 1'b1;
    end
endmodule

// File: rtl/intchain_slot.sv
// Module: one card's interrupt slot in a serial priority chain.
// Latches the device request, pulls the shared request line, blocks the
// chain toward lower cards, and drives its vector when acknowledged with
// an enabled chain input. Pass-through mode forwards the chain only.
// Assumes: chain_in of the first slot is tied 1; bus wiring resolves
// intrq_pull and data_oe/data_out.
module intchain_slot #(
    parameter int                       VEC_W       = 8,
    parameter int                       SYNC_STAGES = 2,
    parameter intchain_pkg::slot_mode_e MODE        = intchain_pkg::MODE_ARB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dev_req,
    input  logic [VEC_W-1:0] vec_sel,
    input  logic             chain_in,
    output logic             chain_out,
    input  logic             intak_n,
    output logic             intrq_pull,
    output logic [VEC_W-1:0] data_out,
    output logic             data_oe
);
    generate
        if (MODE == intchain_pkg::MODE_ARB) begin : g_arb
            logic ack, ack_end, req_q, served_q, oe;
            logic [VEC_W-1:0] data;

            intchain_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk(clk), .rst_n(rst_n), .intak_n(intak_n),
                .ack(ack), .ack_end(ack_end)
            );

            intchain_req_latch u_req (
                .clk(clk), .rst_n(rst_n), .set_req(dev_req),
                .clr_req(ack_end & served_q), .req_q(req_q)
            );

            intchain_vec_drive #(.VEC_W(VEC_W)) u_drv (
                .clk(clk), .rst_n(rst_n), .ack(ack), .ack_end(ack_end),
                .req_q(req_q), .chain_in(chain_in), .vec_sel(vec_sel),
                .oe(oe), .data(data), .served_q(served_q)
            );

            assign chain_out  = chain_in & ~req_q;
            assign intrq_pull = req_q;
            assign data_oe    = oe;
            assign data_out   = data;
        end else begin : g_pass
            assign chain_out  = chain_in;
            assign intrq_pull = 1'b0;
            assign data_oe    = 1'b0;
            assign data_out   = '0;
        end
    endgenerate
endmodule

// File: rtl/intchain_slot_chk.sv
// Module: property checker for intchain_slot, attached by bind.
module intchain_slot_chk #(
    parameter int                       VEC_W = 8,
    parameter intchain_pkg::slot_mode_e MODE  = intchain_pkg::MODE_ARB
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dev_req,
    input logic [VEC_W-1:0] vec_sel,
    input logic             chain_in,
    input logic             chain_out,
    input logic             intak_n,
    input logic             intrq_pull,
    input logic [VEC_W-1:0] data_out,
    input logic             data_oe
);
    AST_BLOCK_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        intrq_pull |-> !chain_out); // R3
    AST_PASS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_in && !intrq_pull) |-> chain_out); // R3
    AST_DRIVE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (chain_in && intrq_pull && data_out == vec_sel)); // R4
    AST_REQ_FROM_DEVICE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intrq_pull) |-> $past(dev_req)); // R2
    AST_CLEAR_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(intrq_pull) |-> $past(intak_n)); // R6
    generate
        if (MODE == intchain_pkg::MODE_PASS) begin : g_pass_chk
            AST_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
                (chain_out == chain_in) && !intrq_pull && !data_oe); // R7
        end
    endgenerate
endmodule

bind intchain_slot intchain_slot_chk #(.VEC_W(VEC_W), .MODE(MODE)) u_chk (.*);

// File: tb/intchain_slot_bench.sv
`timescale 1ns/1ps
module intchain_slot_bench;
    localparam int N     = 4;
    localparam int VEC_W = 8;
    localparam int PASS_IDX = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] dev_req = '0;
    logic [VEC_W-1:0] vec [N];
    logic intak_n = 1'b1;
    logic [N:0] chain;
    logic [N-1:0] pull, oe;
    logic [VEC_W-1:0] dout [N];

    int checks = 0;
    int failures = 0;
    bit exp_req [N];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign chain[0] = 1'b1;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_slot
            if (gi == PASS_IDX) begin : g_p
                intchain_slot #(.VEC_W(VEC_W), .MODE(intchain_pkg::MODE_PASS)) u_intchain_slot (
                    .clk(clk), .rst_n(rst_n), .dev_req(dev_req[gi]), .vec_sel(vec[gi]),
                    .chain_in(chain[gi]), .chain_out(chain[gi+1]), .intak_n(intak_n),
                    .intrq_pull(pull[gi]), .data_out(dout[gi]), .data_oe(oe[gi]));
            end else begin : g_a
                intchain_slot #(.VEC_W(VEC_W), .MODE(intchain_pkg::MODE_ARB)) u_intchain_slot (
                    .clk(clk), .rst_n(rst_n), .dev_req(dev_req[gi]), .vec_sel(vec[gi]),
                    .chain_in(chain[gi]), .chain_out(chain[gi+1]), .intak_n(intak_n),
                    .intrq_pull(pull[gi]), .data_out(dout[gi]), .data_oe(oe[gi]));
            end
        end
    endgenerate

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int winner();
        for (int i = 0; i < N; i++) if (exp_req[i]) return i;
        return -1;
    endfunction

    function automatic bit exp_chain(int k);
        for (int i = 0; i < k; i++) if (exp_req[i]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check_static(string tag);
        bit any = 1'b0;
        for (int i = 0; i < N; i++) begin
            chk(tag, $sformatf("chain_out[%0d] R3", i), chain[i+1], exp_chain(i+1));
            chk(tag, $sformatf("pull[%0d] R2", i), pull[i], exp_req[i]);
            any |= exp_req[i];
        end
        chk(tag, "shared request line R2", !(|pull), !any);
    endtask

    function automatic int bus_val();
        int v = 0;
        for (int i = 0; i < N; i++) if (oe[i]) v |= dout[i];
        return v;
    endfunction

    task automatic do_ack(string tag);
        int w = winner();
        @(negedge clk) intak_n = 1'b0;
        repeat (3) @(negedge clk);
        if (w < 0) begin
            chk(tag, "no driver R8", $countones(oe), 0);
        end else begin
            chk(tag, "single driver R5", $countones(oe), 1);
            chk(tag, "driver position R5", oe[w], 1);
            chk(tag, "bus vector R4", bus_val(), vec[w]);
        end
        chk(tag, "pass slot never drives R7", oe[PASS_IDX], 0);
        intak_n = 1'b1;
        repeat (4) @(negedge clk);
        if (w >= 0) exp_req[w] = 1'b0;
        check_static({tag, " after ack R6"});
    endtask

    task automatic pulse_req(logic [N-1:0] m);
        @(negedge clk) dev_req = m;
        @(negedge clk) dev_req = '0;
        for (int i = 0; i < N; i++) if (m[i] && i != PASS_IDX) exp_req[i] = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) begin vec[i] = VEC_W'(8'h30 + 8'(i * 23)); exp_req[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_static("R1 reset");
        chk("R1", "no oe after reset", $countones(oe), 0);

        do_ack("R8 idle ack");

        pulse_req(4'b1000);
        check_static("R2 single low slot");
        do_ack("R4 lowest only");

        pulse_req(4'b1011);
        check_static("R3 three requesters");
        do_ack("R5 first");
        do_ack("R6 second");
        do_ack("R6 third");

        pulse_req(4'b0100);
        check_static("R7 pass slot request ignored");
        do_ack("R7 pass ack");

        for (int r = 0; r < 40; r++) begin
            for (int i = 0; i < N; i++) vec[i] = VEC_W'($urandom);
            pulse_req(N'($urandom));
            check_static("R3 random");
            do_ack("R5 random");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule